// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Access

This block is a serial peripheral master that software drives through a small set of 32-bit word registers on a plain read/write bus. Writing a byte to the transmit register starts one full-duplex exchange of exactly eight bits. Each bit goes out on the data output while a bit comes in on the data input. The received byte is latched into the receive register, and a status flag reports that it has arrived.

The serial clock comes from the system clock in two stages. The first stage is a fixed prescaler, either 16 or 128. The second stage is a programmable even divider. Clock polarity and phase are register fields. The single chip-select line is not strobed by the hardware: software sets its level through a register bit around a run of byte exchanges.

A typical driver sequence is:
1. Program the mode and divider.
2. Enable the block and pull chip-select low.
3. For each byte, poll the busy flag, write the transmit byte, wait for the receive flag, and read the received byte.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0, chip-select is low, the serial clock is low and the busy flag is clear.
- R2: The register map decodes as follows:
  - word offset 0x00 is the mode register and keeps bits 7:0;
  - 0x08 is the system register and keeps bits 7:0;
  - 0x14 is a general 32-bit register and keeps all bits;
  - 0x0C reads back the last byte accepted for transmission;
  - any unmapped offset reads 0.
- R3: The chip-select output equals bit 6 of the system register, one clock after the write.
- R4: A write to 0x0C starts an exchange when system bit 0 is 1 and no exchange is running. Status bit 0 then reads 1 for exactly 16·P·(N+1) clock cycles, starting in the cycle after the write. P is 128 when mode bit 5 is 1 and 16 when it is 0; N is mode bits 4:0.
- R5: The serial clock rests at the level of mode bit 6 whenever no exchange runs, and it toggles 16 times per exchange.
- R6: Data moves most significant bit first, with mode bit 7 selecting the phase:
  - mode bit 7 = 0: the first output bit is valid before the first clock edge, and input is sampled on leading edges;
  - mode bit 7 = 1: output changes on leading edges, and input is sampled on trailing edges.
  
  The peer receives the transmit low byte, and 0x10 then reads the peer's byte. This holds in all four clock modes.
- R7: Status bit 2 is set when an exchange ends. A read of 0x10 clears it.
- R8: A write to 0x04 with bit 2 equal to 0 clears status bit 2.
- R9: A write to 0x0C while an exchange runs is ignored. The running exchange and the 0x0C readback are unchanged.
- R10: A write to 0x0C while system bit 0 is 0 starts nothing and leaves the 0x0C readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, captured at the rising edge |
| bus_rd | input | 1 | Read strobe; used only for read side effects |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip-select, level set by software |

## Verification
Register writes land at the rising edge that captures the strobe, so their effects (chip-select level, readback, start of busy) are sampled at the following falling edge. Read data is combinational, so it is sampled in the same cycle as the address. The busy window is counted falling edge by falling edge from the first sample after the transmit write, and it must equal 16·P·(N+1) exactly. Received data and the receive flag are checked only after busy has dropped. A peer model on the serial lines drives and samples on the edges R6 defines, which catches any phase or bit-order slip.

// File: rtl/spi_byte_master_pkg.sv
// Package: shared register indices and field positions for the byte SPI master.
// Assumes 32-bit registers decoded on word addresses (byte address bits 1:0 ignored).
package spi_byte_master_pkg;
    localparam int REG_W     = 32;
    localparam int IDX_W     = 6;
    localparam logic [IDX_W-1:0] IDX_MODE = 6'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 6'd1;
    localparam logic [IDX_W-1:0] IDX_SYS  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_TX   = 6'd3;
    localparam logic [IDX_W-1:0] IDX_RX   = 6'd4;
    localparam logic [IDX_W-1:0] IDX_AUX  = 6'd5;
    localparam int MODE_PHASE  = 7;
    localparam int MODE_POL    = 6;
    localparam int MODE_PRESEL = 5;
    localparam int SYS_CS      = 6;
    localparam int SYS_EN      = 0;
    localparam int STAT_BUSY   = 0;
    localparam int STAT_RXF    = 2;
endpackage

// File: rtl/sbm_clkgen.sv
// Module: two-stage serial clock tick generator.
// Emits one half_tick per half serial period: every PRE*(div_n+1) cycles,
// PRE being PRE_LO or PRE_HI. Counters are held at zero while run is low,
// so the first tick after run rises lands exactly one half period later.
module sbm_clkgen #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int DIV_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             half_tick
);
    localparam int PCNT_W = $clog2(PRE_HI);
    localparam logic [PCNT_W-1:0] LIM_HI = PCNT_W'(PRE_HI - 1);
    localparam logic [PCNT_W-1:0] LIM_LO = PCNT_W'(PRE_LO - 1);

    logic [PCNT_W-1:0] pcnt;
    logic [DIV_W-1:0]  dcnt;
    logic              pre_tick;

    // Purpose: end of one prescaler period while running.
    always_comb pre_tick = run && (pcnt == (pre_sel ? LIM_HI : LIM_LO));
    // Purpose: end of one half serial period.
    always_comb half_tick = pre_tick && (dcnt == div_n);

    // Purpose: first-stage prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  pcnt <= '0;
        else if (pre_tick)   pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // Purpose: second-stage divider counter, advanced by prescaler ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  dcnt <= '0;
        else if (half_tick)  dcnt <= '0;
        else if (pre_tick)   dcnt <= dcnt + 1'b1;
    end
endmodule

// File: rtl/sbm_shifter.sv
// Module: one-word full-duplex shift engine, MSB first.
// Counts 2*WORD_W clock edges paced by half_tick. The phase is latched at start.
// Phase 0: output preset before the first edge; input sampled on even (leading)
// edges; output shifts on odd (trailing) edges.
// Phase 1: output shifts on leading edges; input sampled on trailing edges.
module sbm_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              cpha,
    input  logic              half_tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              mosi,
    output logic              phase
);
    localparam int EDGES  = 2 * WORD_W;
    localparam int ECNT_W = $clog2(EDGES);
    localparam logic [ECNT_W-1:0] LAST = ECNT_W'(EDGES - 1);

    logic [ECNT_W-1:0] ecnt;
    logic [WORD_W-1:0] txs, rxs;
    logic              cpha_q, leading, do_sample, do_shift;

    // Purpose: classify the current edge as leading or trailing.
    always_comb leading = ~ecnt[0];
    // Purpose: choose the sampling edge for the latched phase.
    always_comb do_sample = busy && half_tick && (cpha_q ? !leading : leading);
    // Purpose: choose the output-shifting edge for the latched phase.
    always_comb do_shift = busy && half_tick &&
                           (cpha_q ? leading : (!leading && ecnt != LAST));
    // Purpose: flag the final edge of the word.
    always_comb done = busy && half_tick && (ecnt == LAST);
    // Purpose: assemble the received word; phase 1 takes its last bit on the final edge.
    always_comb rx_word = cpha_q ? {rxs[WORD_W-2:0], miso} : rxs;

    // Purpose: engine control state (busy, edge count, clock phase).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            ecnt   <= '0;
            phase  <= 1'b0;
            cpha_q <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            ecnt   <= '0;
            phase  <= 1'b0;
            cpha_q <= cpha;
        end else if (busy && half_tick) begin
            phase <= ~phase;
            ecnt  <= ecnt + 1'b1;
            if (ecnt == LAST) busy <= 1'b0;
        end
    end

    // Purpose: transmit shift register and data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txs  <= '0;
            mosi <= 1'b0;
        end else if (start) begin
            txs  <= cpha ? tx_word : {tx_word[WORD_W-2:0], 1'b0};
            mosi <= cpha ? 1'b0 : tx_word[WORD_W-1];
        end else if (do_shift) begin
            mosi <= txs[WORD_W-1];
            txs  <= {txs[WORD_W-2:0], 1'b0};
        end
    end

    // Purpose: receive shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)          rxs <= '0;
        else if (start)      rxs <= '0;
        else if (do_sample)  rxs <= {rxs[WORD_W-2:0], miso};
    end
endmodule

// File: rtl/spi_byte_master.sv
// Module: register-mapped SPI master, one byte per exchange.
// Holds the register file, decodes the bus and wires the clock generator to the
// shift engine. Assumes single-cycle write/read strobes and a combinational read.
// Chip-select is purely a register level.
module spi_byte_master
    import spi_byte_master_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 8,
    parameter int DIV_W  = 5,
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic [IDX_W-1:0]  idx;
    logic [7:0]        mode_q, sys_q;
    logic [REG_W-1:0]  aux_q;
    logic [WORD_W-1:0] tx_q, rx_q, rx_word;
    logic              rxfull_q, xfer_busy, xfer_done, half_tick, phase, start;

    // Purpose: word index of the current bus address.
    always_comb idx = IDX_W'(bus_addr[ADDR_W-1:2]);
    // Purpose: accept a transmit write only when enabled and idle.
    always_comb start = bus_wr && (idx == IDX_TX) && sys_q[SYS_EN] && !xfer_busy;

    // Purpose: mode, system and general registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            sys_q  <= '0;
            aux_q  <= '0;
        end else if (bus_wr) begin
            if (idx == IDX_MODE) mode_q <= bus_wdata[7:0];
            if (idx == IDX_SYS)  sys_q  <= bus_wdata[7:0];
            if (idx == IDX_AUX)  aux_q  <= bus_wdata;
        end
    end

    // Purpose: last accepted transmit word.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_q <= '0;
        else if (start)  tx_q <= bus_wdata[WORD_W-1:0];
    end

    // Purpose: receive buffer and receive-full flag; a completing exchange wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rxfull_q <= 1'b0;
        end else if (xfer_done) begin
            rx_q     <= rx_word;
            rxfull_q <= 1'b1;
        end else if (bus_rd && idx == IDX_RX) begin
            rxfull_q <= 1'b0;
        end else if (bus_wr && idx == IDX_STAT && !bus_wdata[STAT_RXF]) begin
            rxfull_q <= 1'b0;
        end
    end

    // Purpose: read-data multiplexer.
    always_comb begin
        unique case (idx)
            IDX_MODE: bus_rdata = REG_W'(mode_q);
            IDX_STAT: bus_rdata = REG_W'({rxfull_q, 1'b0, xfer_busy});
            IDX_SYS:  bus_rdata = REG_W'(sys_q);
            IDX_TX:   bus_rdata = REG_W'(tx_q);
            IDX_RX:   bus_rdata = REG_W'(rx_q);
            IDX_AUX:  bus_rdata = aux_q;
            default:  bus_rdata = '0;
        endcase
    end

    // Purpose: serial clock at the polarity level, inverted on odd half periods.
    always_comb spi_sclk = mode_q[MODE_POL] ^ phase;
    // Purpose: chip-select straight from the system register.
    always_comb spi_cs_n = sys_q[SYS_CS];

    sbm_clkgen #(
        .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (xfer_busy),
        .pre_sel   (mode_q[MODE_PRESEL]),
        .div_n     (mode_q[DIV_W-1:0]),
        .half_tick (half_tick)
    );

    sbm_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_word   (bus_wdata[WORD_W-1:0]),
        .cpha      (mode_q[MODE_PHASE]),
        .half_tick (half_tick),
        .miso      (spi_miso),
        .busy      (xfer_busy),
        .done      (xfer_done),
        .rx_word   (rx_word),
        .mosi      (spi_mosi),
        .phase     (phase)
    );
endmodule

// File: rtl/spi_byte_master_chk.sv
// Module: protocol checker for spi_byte_master, attached by bind.
// Observes the bus, the serial pins and a few register outputs.
module spi_byte_master_chk
    import spi_byte_master_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic              busy,
    input logic              en,
    input logic              cpol,
    input logic [WORD_W-1:0] tx_q,
    input logic              rxfull
);
    logic [IDX_W-1:0] idx;

    // Purpose: decode the word index seen on the bus.
    always_comb idx = IDX_W'(bus_addr[ADDR_W-1:2]);

    p_cs_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && idx == IDX_SYS |=> spi_cs_n == $past(bus_wdata[SYS_CS]));

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && idx == IDX_TX && en && !busy |=> busy);

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_sclk == cpol);

    p_rx_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && idx == IDX_RX && !busy |=> !rxfull);

    p_stat_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && idx == IDX_STAT && !bus_wdata[STAT_RXF] && !busy |=> !rxfull);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bus_wr && idx == IDX_TX |=> tx_q == $past(tx_q));

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !en |=> !busy);
endmodule

bind spi_byte_master spi_byte_master_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .busy      (xfer_busy),
    .en        (sys_q[0]),
    .cpol      (mode_q[6]),
    .tx_q      (tx_q),
    .rxfull    (rxfull_q)
);

// File: tb/spi_byte_master_test.sv
// Bench: seeded random exchanges plus directed corner cases, with a peer model on the serial pins.
module spi_byte_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // peer model state
    bit [7:0] slv_out, slv_in;
    int       slv_ptr, slv_edges;
    bit       slv_cpol, slv_cpha;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_byte_master #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // peer: drives and samples on the edges selected by its phase
    always @(spi_sclk) begin
        bit lead;
        lead = (spi_sclk != slv_cpol);
        slv_edges++;
        if (slv_cpha == 1'b0) begin
            if (lead) slv_in = {slv_in[6:0], spi_mosi};
            else if (slv_ptr >= 0) begin spi_miso = slv_out[slv_ptr]; slv_ptr--; end
        end else begin
            if (lead) begin
                if (slv_ptr >= 0) begin spi_miso = slv_out[slv_ptr]; slv_ptr--; end
            end else slv_in = {slv_in[6:0], spi_mosi};
        end
    end

    task automatic arm(input bit [7:0] b, input bit pol, input bit pha);
        slv_out = b; slv_in = '0; slv_edges = 0; slv_cpol = pol; slv_cpha = pha;
        if (pha) begin slv_ptr = 7; spi_miso = 1'b0; end
        else begin slv_ptr = 6; spi_miso = b[7]; end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int exp_busy(input bit presel, input int n);
        return 16 * (presel ? 128 : 16) * (n + 1);
    endfunction

    // One exchange; optionally reads the receive register afterwards.
    task automatic xfer(input bit pol, input bit pha, input bit presel, input int n,
                        input bit [7:0] txb, input bit [7:0] slvb, input bit read_rx);
        logic [31:0] d;
        int cnt;
        wr(8'h00, {24'h0, pha, pol, presel, 5'(n)});
        arm(slvb, pol, pha);
        #1 check(spi_sclk == pol, "R5 idle level", 32'(spi_sclk), 32'(pol));
        wr(8'h0C, {24'hABCDEF, txb});
        bus_addr = 8'h04;
        cnt = 0;
        #1;
        while (bus_rdata[0]) begin cnt++; @(negedge clk); #1; end
        check(cnt == exp_busy(presel, n), "R4 busy cycles", cnt, exp_busy(presel, n));
        check(slv_edges == 16, "R5 edge count", slv_edges, 16);
        check(spi_sclk == pol, "R5 rest level", 32'(spi_sclk), 32'(pol));
        check(slv_in == txb, "R6 peer received", 32'(slv_in), 32'(txb));
        check(bus_rdata[2] == 1'b1, "R7 rxfull set", bus_rdata, 32'h4);
        if (read_rx) begin
            rd(8'h10, d);
            check(d == {24'h0, slvb}, "R6 rx byte", d, {24'h0, slvb});
            rd(8'h04, d);
            check(d == 32'h0, "R7 rxfull cleared by read", d, 32'h0);
        end
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd1234));
        arm(8'h00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), d);
            check(d == 32'h0, "R1 reset reg", d, 32'h0);
        end
        check(spi_cs_n == 1'b0, "R1 cs low", 32'(spi_cs_n), 0);
        check(spi_sclk == 1'b0, "R1 sclk low", 32'(spi_sclk), 0);

        // R2 register map
        wr(8'h00, 32'hFFFF_FF45); rd(8'h00, d);
        check(d == 32'h45, "R2 mode readback", d, 32'h45);
        wr(8'h14, 32'hDEAD_BEEF); rd(8'h14, d);
        check(d == 32'hDEAD_BEEF, "R2 general readback", d, 32'hDEAD_BEEF);
        rd(8'h18, d);
        check(d == 32'h0, "R2 unmapped", d, 32'h0);

        // R3 chip-select level
        wr(8'h08, 32'h61); #1;
        check(spi_cs_n == 1'b1, "R3 cs high", 32'(spi_cs_n), 1);
        rd(8'h08, d);
        check(d == 32'h61, "R2 system readback", d, 32'h61);

        // R10 disabled: transmit write ignored
        wr(8'h00, 32'h0);
        arm(8'h00, 1'b0, 1'b0);
        wr(8'h08, 32'h20);
        wr(8'h0C, 32'h5A);
        rd(8'h04, d);
        check(d[0] == 1'b0, "R10 no busy", d, 32'h0);
        rd(8'h0C, d);
        check(d == 32'h0, "R10 tx readback", d, 32'h0);
        repeat (300) @(negedge clk);
        check(slv_edges == 0, "R10 no clock", slv_edges, 0);

        wr(8'h08, 32'h21); #1;
        check(spi_cs_n == 1'b0, "R3 cs low", 32'(spi_cs_n), 0);

        // directed: all four modes, extreme bytes, slow prescaler
        xfer(0, 0, 0, 0, 8'h80, 8'h01, 1);
        xfer(1, 0, 0, 1, 8'h01, 8'h80, 1);
        xfer(0, 1, 0, 0, 8'hFF, 8'h00, 1);
        xfer(1, 1, 1, 0, 8'hA5, 8'h3C, 1);
        rd(8'h0C, d);
        check(d == 32'hA5, "R2 tx readback", d, 32'hA5);

        // seeded random exchanges
        for (int i = 0; i < 14; i++) begin
            bit [2:0] m;
            m = 3'($urandom);
            xfer(m[0], m[1], 1'b0, int'($urandom % 4), 8'($urandom), 8'($urandom), 1);
        end

        // R8 status write clears receive flag
        xfer(0, 1, 0, 2, 8'h3E, 8'hC7, 0);
        wr(8'h04, 32'h0);
        rd(8'h04, d);
        check(d == 32'h0, "R8 status cleared", d, 32'h0);
        rd(8'h10, d);
        check(d == 32'hC7, "R8 rx kept", d, 32'hC7);

        // R9 transmit write while busy ignored
        wr(8'h00, 32'h0);
        arm(8'h96, 1'b0, 1'b0);
        wr(8'h0C, 32'h69);
        repeat (100) @(negedge clk);
        wr(8'h0C, 32'hF0);
        rd(8'h0C, d);
        check(d == 32'h69, "R9 tx readback", d, 32'h69);
        bus_addr = 8'h04; #1;
        while (bus_rdata[0]) begin @(negedge clk); #1; end
        check(slv_in == 8'h69, "R9 peer got original", 32'(slv_in), 32'h69);
        check(slv_edges == 16, "R9 single exchange", slv_edges, 16);
        rd(8'h10, d);
        check(d == 32'h96, "R9 rx byte", d, 32'h96);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule